// File: doc/BRIEF.md
# March Memory Self-Test Controller with Failure Datalog

This block runs a march-style self-test on the small memory array it contains. A tester sets up a test as follows. It first flushes the controller by holding reset low long enough with the test-mode enable high. It then shifts an 8-bit instruction in serially and raises a run request. The instruction picks one of three algorithms, a data background and whether the run works in bitmap mode. A fault-injection hook can corrupt the read data of one chosen address.

Without bitmap mode, a run goes from start to finish and only accumulates a sticky fail flag. With bitmap mode, the controller freezes on the cycle of each miscompare and raises a wait flag. It then hands a 23-bit failure record to the tester over a serial output. When the last record bit has been clocked out, it continues with the memory operation that follows the failing read. This repeats for every failure until the run ends. A second serial register, loaded when both shift enables are high, sets how many miscompares are tolerated before the fail flag rises.

Top module: `mbist_ctrl`

## Requirements
- R1: The controller is armed only when reset has been low for at least 15 consecutive rising clock edges. After a shorter reset pulse, every load and run request is ignored and `result` stays 3'b000.
- R2: If `test_en` is low at any rising edge during the reset pulse, the controller is not armed, with the same effect as in R1.
- R3: Instruction bits travel on `sdi` one cycle behind `ins_shift`, LSB first. The bit present at an edge is stored when `ins_shift` was high at the previous edge and `gng_shift` was low there. Eight bits are stored: bits [1:0] select the algorithm, bit 2 enables bitmap mode, and bits [7:3] form the background B. The data pattern P has P[i] = B[i mod 5].
- R4: When both enables were high at the previous edge, the incoming bit goes LSB first into the 8-bit fail-limit register instead of the instruction register. This load may follow an instruction load without a gap. Both registers reset to zero.
- R5: A run request taken at an edge when the controller is armed and idle, an instruction bit has been stored and `ins_shift` is low starts the test. If that edge also stores the last lagged instruction bit, the test uses the complete instruction.
- R6: Algorithm 0 performs one operation per cycle on the 16 words. The elements, each covering every address, are: element 0, up: write P. Element 1, up: read P, then write ~P. Element 2, up: read ~P, then write P. Element 3, down: read P, then write ~P. Element 4, down: read ~P, then write P. Element 5, up: read P. Algorithms 1 (checkerboard, the base is P inverted at odd addresses) and 2 or 3 (solid, the base is P) run four up elements: write base, read base, write ~base, read ~base.
- R7: In bitmap mode, the cycle that detects a miscompare is the last memory operation before the controller halts. From the next cycle `result[1]` stays high until an edge where `gng_shift` is high and `ins_shift` is low.
- R8: The failure record is {address[3:0], expected[7:0], read[7:0], element[2:0]}. It is shown MSB first on `sdo`, and each edge with `gng_shift` high and `ins_shift` low moves it by one bit. `sdo` is 0 when no record is pending.
- R9: After the 23rd shift the test resumes with the operation that follows the failing read, so no operation is repeated or skipped. The handshake repeats for every failure.
- R10: Without bitmap mode, a miscompare never halts the test.
- R11: `result[0]` rises once the last operation is done. If that operation failed in bitmap mode, it rises only after its record has been shifted out. It then holds until reset.
- R12: `result[2]` is set by a miscompare when the number of earlier miscompares (saturating at 255) is at least the fail limit. It then holds until reset.
- R13: While `fault_en` is high, reads of `fault_addr` return the stored word XOR `fault_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its length decides arming |
| test_en | input | 1 | Test-mode enable, sampled during reset |
| ins_shift | input | 1 | Instruction shift enable |
| gng_shift | input | 1 | Secondary enable: fail-limit load or datalog shift |
| sdi | input | 1 | Serial data in, one cycle behind the enables |
| run_req | input | 1 | Test start request |
| fault_en | input | 1 | Enables read corruption |
| fault_addr | input | 4 | Word address that is corrupted |
| fault_mask | input | 8 | Bits flipped on a corrupted read |
| sdo | output | 1 | Serial failure record, MSB first |
| result | output | 3 | [0] done, [1] halted on a failure, [2] sticky fail |

## Verification
Two events can land on the same edge: the last instruction bit, which arrives one cycle after `ins_shift` falls, and a run request. The bench raises `run_req` on exactly the edge that stores bit 7. It judges the run by the expected data in the failure records and by an every-cycle comparison against the behavioural model, which fills its own operation list from the complete instruction. A second collision is a miscompare on the very last operation of a bitmap run. There the bench checks that the done bit stays low through the halt and rises only after the record has been shifted out.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int unsigned ELEM_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_HALT = 3'd2,
    ST_DUMP = 3'd3,
    ST_DONE = 3'd4
  } ctl_st_e;

  typedef enum logic [1:0] {
    ALG_MARCHC  = 2'd0,
    ALG_CHECKER = 2'd1,
    ALG_SOLID   = 2'd2,
    ALG_SOLID_B = 2'd3
  } alg_e;

  // One march element: up to two operations at each address
  typedef struct packed {
    logic two_ops;
    logic down;
    logic rd0;
    logic v0;
    logic rd1;
    logic v1;
    logic final_el;
  } elem_desc_t;

  function automatic elem_desc_t elem_desc(input logic [1:0] alg,
                                           input logic [ELEM_W-1:0] el);
    elem_desc_t d;
    d = '0;
    if (alg == ALG_MARCHC) begin
      case (el)
        3'd0: d.rd0 = 1'b0;
        3'd1: begin d.two_ops = 1'b1; d.rd0 = 1'b1; d.v1 = 1'b1; end
        3'd2: begin d.two_ops = 1'b1; d.rd0 = 1'b1; d.v0 = 1'b1; end
        3'd3: begin d.two_ops = 1'b1; d.down = 1'b1; d.rd0 = 1'b1; d.v1 = 1'b1; end
        3'd4: begin d.two_ops = 1'b1; d.down = 1'b1; d.rd0 = 1'b1; d.v0 = 1'b1; end
        default: begin d.rd0 = 1'b1; d.final_el = 1'b1; end
      endcase
    end else begin
      case (el)
        3'd0: d.rd0 = 1'b0;
        3'd1: d.rd0 = 1'b1;
        3'd2: d.v0 = 1'b1;
        default: begin d.rd0 = 1'b1; d.v0 = 1'b1; d.final_el = 1'b1; end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/mbist_loader.sv
module mbist_loader #(
  parameter int unsigned IW        = 8,
  parameter int unsigned LIM_W     = 8,
  parameter int unsigned FLUSH_CYC = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             ins_shift,
  input  logic             gng_shift,
  input  logic             sdi,
  input  logic             idle,
  output logic             armed,
  output logic [IW-1:0]    instr,
  output logic [LIM_W-1:0] lim,
  output logic             loaded
);

  localparam int unsigned FCW = $clog2(FLUSH_CYC + 1);
  localparam logic [FCW-1:0] F_MAX = FCW'(FLUSH_CYC);

  // Flush detection: plain clocked registers so they can count through reset
  logic           rst_q;
  logic [FCW-1:0] fcnt, fcnt_n;
  logic           te_ok, te_ok_n;
  logic           armed_q, armed_n;

  always_comb begin
    if (rst_q) begin
      fcnt_n  = FCW'(1);
      te_ok_n = test_en;
    end else begin
      fcnt_n  = (fcnt == F_MAX) ? fcnt : fcnt + 1'b1;
      te_ok_n = te_ok & test_en;
    end
    armed_n = (fcnt_n == F_MAX) && te_ok_n;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (!rst_n) begin
      fcnt    <= fcnt_n;
      te_ok   <= te_ok_n;
      armed_q <= armed_n;
    end
  end

  assign armed = armed_q;

  // Serial loads, data one cycle behind the enables
  logic             ins_q, gng_q;
  logic             cap_i, cap_g;
  logic [IW-1:0]    instr_q, instr_n;
  logic [LIM_W-1:0] lim_q, lim_n;
  logic             loaded_q, loaded_n;

  always_comb begin
    cap_i    = armed_q && idle && ins_q && !gng_q;
    cap_g    = armed_q && idle && ins_q && gng_q;
    instr_n  = cap_i ? {sdi, instr_q[IW-1:1]} : instr_q;
    lim_n    = cap_g ? {sdi, lim_q[LIM_W-1:1]} : lim_q;
    loaded_n = loaded_q | cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q    <= 1'b0;
      gng_q    <= 1'b0;
      instr_q  <= '0;
      lim_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      ins_q    <= ins_shift;
      gng_q    <= gng_shift;
      instr_q  <= instr_n;
      lim_q    <= lim_n;
      loaded_q <= loaded_n;
    end
  end

  assign instr  = instr_q;
  assign lim    = lim_q;
  assign loaded = loaded_q;

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int unsigned AW  = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned BGW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [1:0]        alg,
  input  logic [BGW-1:0]    bg,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     data,
  output logic              rd,
  output logic              last,
  output logic [ELEM_W-1:0] elem
);

  elem_desc_t        d;
  logic [AW-1:0]     acnt, acnt_n;
  logic [ELEM_W-1:0] el, el_n;
  logic              opi, opi_n;
  logic [DW-1:0]     pat, base;
  logic              val;

  for (genvar gi = 0; gi < DW; gi++) begin : g_pat
    assign pat[gi] = bg[gi % BGW];
  end

  always_comb begin
    d    = elem_desc(alg, el);
    addr = d.down ? ~acnt : acnt;
    base = pat ^ (((alg == ALG_CHECKER) && addr[0]) ? {DW{1'b1}} : {DW{1'b0}});
    val  = opi ? d.v1 : d.v0;
    data = val ? ~base : base;
    rd   = opi ? d.rd1 : d.rd0;
    last = (opi == d.two_ops) && (&acnt) && d.final_el;
    elem = el;
  end

  always_comb begin
    acnt_n = acnt;
    el_n   = el;
    opi_n  = opi;
    if (start) begin
      acnt_n = '0;
      el_n   = '0;
      opi_n  = 1'b0;
    end else if (adv) begin
      if (!opi && d.two_ops) begin
        opi_n = 1'b1;
      end else begin
        opi_n = 1'b0;
        if (&acnt) begin
          acnt_n = '0;
          el_n   = el + 1'b1;
        end else begin
          acnt_n = acnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt <= '0;
      el   <= '0;
      opi  <= 1'b0;
    end else begin
      acnt <= acnt_n;
      el   <= el_n;
      opi  <= opi_n;
    end
  end

endmodule

// File: rtl/mbist_mem.sv
module mbist_mem #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          fault_en,
  input  logic [AW-1:0] fault_addr,
  input  logic [DW-1:0] fault_mask,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
  end

  always_comb begin
    rdata = arr[addr];
    if (fault_en && (addr == fault_addr)) rdata = rdata ^ fault_mask;
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned IW        = 8,
  parameter int unsigned LIM_W     = 8,
  parameter int unsigned FLUSH_CYC = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_en,
  input  logic          ins_shift,
  input  logic          gng_shift,
  input  logic          sdi,
  input  logic          run_req,
  input  logic          fault_en,
  input  logic [AW-1:0] fault_addr,
  input  logic [DW-1:0] fault_mask,
  output logic          sdo,
  output logic [2:0]    result
);

  localparam int unsigned BGW = IW - 3;
  localparam int unsigned LW  = AW + 2 * DW + ELEM_W;
  localparam int unsigned BCW = $clog2(LW + 1);
  localparam logic [BCW-1:0] BC_LAST = BCW'(LW - 1);

  ctl_st_e st, st_n;

  logic              armed, loaded;
  logic [IW-1:0]     instr;
  logic [LIM_W-1:0]  lim;
  logic              bitmap;
  logic [AW-1:0]     s_addr;
  logic [DW-1:0]     s_data, rdata;
  logic              s_rd, s_last;
  logic [ELEM_W-1:0] s_elem;
  logic              go, seq_adv, mem_we, miscmp, pull;

  logic [LW-1:0]    rec, rec_n;
  logic [BCW-1:0]   bc, bc_n;
  logic             fin, fin_n;
  logic [LIM_W-1:0] nf, nf_n;
  logic             flag, flag_n;

  mbist_loader #(.IW(IW), .LIM_W(LIM_W), .FLUSH_CYC(FLUSH_CYC)) u_load (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .ins_shift(ins_shift),
    .gng_shift(gng_shift), .sdi(sdi), .idle(st == ST_IDLE),
    .armed(armed), .instr(instr), .lim(lim), .loaded(loaded)
  );

  mbist_seq #(.AW(AW), .DW(DW), .BGW(BGW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go), .adv(seq_adv),
    .alg(instr[1:0]), .bg(instr[IW-1:3]),
    .addr(s_addr), .data(s_data), .rd(s_rd), .last(s_last), .elem(s_elem)
  );

  mbist_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .addr(s_addr), .wdata(s_data),
    .fault_en(fault_en), .fault_addr(fault_addr), .fault_mask(fault_mask),
    .rdata(rdata)
  );

  always_comb begin
    bitmap  = instr[2];
    go      = (st == ST_IDLE) && armed && loaded && run_req && !ins_shift;
    seq_adv = (st == ST_RUN);
    mem_we  = (st == ST_RUN) && !s_rd;
    miscmp  = (st == ST_RUN) && s_rd && (rdata != s_data);
    pull    = gng_shift && !ins_shift;
  end

  always_comb begin
    st_n   = st;
    rec_n  = rec;
    bc_n   = bc;
    fin_n  = fin;
    nf_n   = nf;
    flag_n = flag;
    case (st)
      ST_IDLE: if (go) st_n = ST_RUN;
      ST_RUN: begin
        if (miscmp) begin
          if (nf >= lim) flag_n = 1'b1;
          if (nf != {LIM_W{1'b1}}) nf_n = nf + 1'b1;
        end
        if (miscmp && bitmap) begin
          rec_n = {s_addr, s_data, rdata, s_elem};
          bc_n  = '0;
          fin_n = s_last;
          st_n  = ST_HALT;
        end else if (s_last) begin
          st_n = ST_DONE;
        end
      end
      ST_HALT, ST_DUMP: begin
        if (pull) begin
          rec_n = {rec[LW-2:0], 1'b0};
          if (bc == BC_LAST) begin
            bc_n = '0;
            st_n = fin ? ST_DONE : ST_RUN;
          end else begin
            bc_n = bc + 1'b1;
            st_n = ST_DUMP;
          end
        end
      end
      default: st_n = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      rec  <= '0;
      bc   <= '0;
      fin  <= 1'b0;
      nf   <= '0;
      flag <= 1'b0;
    end else begin
      st   <= st_n;
      rec  <= rec_n;
      bc   <= bc_n;
      fin  <= fin_n;
      nf   <= nf_n;
      flag <= flag_n;
    end
  end

  assign sdo    = ((st == ST_HALT) || (st == ST_DUMP)) ? rec[LW-1] : 1'b0;
  assign result = {flag, st == ST_HALT, st == ST_DONE};

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_shift,
  input logic       gng_shift,
  input logic [2:0] result,
  input logic       sdo,
  input logic       armed,
  input logic       miscmp,
  input logic       bitmap,
  input logic       mem_we,
  input logic       seq_adv
);

  // R1, R2: an unarmed controller reports nothing
  a_r1_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (result == 3'b000) && !sdo);

  // R7: a bitmap miscompare halts on the next cycle
  a_r7_halt_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (miscmp && bitmap) |=> result[1]);

  // R7: halted means no memory traffic and no sequencer movement
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    result[1] |-> !mem_we && !seq_adv);

  // R7: wait flag held until retrieval starts
  a_r7_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (result[1] && !(gng_shift && !ins_shift)) |=> result[1]);

  // R7: wait flag drops once retrieval starts
  a_r7_release_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (result[1] && gng_shift && !ins_shift) |=> !result[1]);

  // R10: no halt without bitmap mode
  a_r10_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (miscmp && !bitmap) |=> !result[1]);

  // R11: done holds
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    result[0] |=> result[0]);

  // R12: fail flag holds
  a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    result[2] |=> result[2]);

  // R11: done and waiting never together
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(result[0] && result[1]));

endmodule

bind mbist_ctrl mbist_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_shift(ins_shift), .gng_shift(gng_shift),
  .result(result), .sdo(sdo), .armed(armed), .miscmp(miscmp),
  .bitmap(bitmap), .mem_we(mem_we), .seq_adv(seq_adv)
);

// File: tb/mbist_ctrl_bench.sv
module mbist_ctrl_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 16;
  localparam int LW = 23;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b1, test_en = 1'b1, ins_shift = 1'b0, gng_shift = 1'b0;
  logic          sdi = 1'b0, run_req = 1'b0, fault_en = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  logic [DW-1:0] fault_mask = '0;
  logic          sdo;
  logic [2:0]    result;

  mbist_ctrl u_mbist_ctrl (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .ins_shift(ins_shift),
    .gng_shift(gng_shift), .sdi(sdi), .run_req(run_req), .fault_en(fault_en),
    .fault_addr(fault_addr), .fault_mask(fault_mask), .sdo(sdo), .result(result)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, want);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   m_rstq = 1'b1, m_ok = 1'b0, m_armed = 1'b0;
  int   m_lc = 0;
  int   m_state = 0;            // 0 idle 1 run 2 halt 3 dump 4 done
  bit   m_insd, m_gngd, m_loaded, m_fin, m_flag;
  logic [7:0]    m_instr, m_lim;
  int   m_nf, m_pos, m_bc;
  logic [LW-1:0] m_rec;
  logic [DW-1:0] m_mem [N];
  int   q_addr[$], q_rd[$], q_elem[$];
  logic [DW-1:0] q_data[$];

  task automatic build_ops(input logic [7:0] ins);
    int nops[6], dn[6], r0[6], v0[6], r1[6], v1[6];
    int ne;
    logic [DW-1:0] pat, base;
    q_addr.delete(); q_rd.delete(); q_elem.delete(); q_data.delete();
    for (int i = 0; i < DW; i++) pat[i] = ins[3 + (i % 5)];
    if (ins[1:0] == 2'd0) begin
      ne = 6;
      nops = '{1, 2, 2, 2, 2, 1}; dn = '{0, 0, 0, 1, 1, 0};
      r0 = '{0, 1, 1, 1, 1, 1};   v0 = '{0, 0, 1, 0, 1, 0};
      r1 = '{0, 0, 0, 0, 0, 0};   v1 = '{0, 1, 0, 1, 0, 0};
    end else begin
      ne = 4;
      nops = '{1, 1, 1, 1, 0, 0}; dn = '{0, 0, 0, 0, 0, 0};
      r0 = '{0, 1, 0, 1, 0, 0};   v0 = '{0, 0, 1, 1, 0, 0};
      r1 = '{0, 0, 0, 0, 0, 0};   v1 = '{0, 0, 0, 0, 0, 0};
    end
    for (int e = 0; e < ne; e++)
      for (int k = 0; k < N; k++) begin
        int a;
        a = (dn[e] != 0) ? (N - 1 - k) : k;
        base = pat ^ (((ins[1:0] == 2'd1) && (a % 2 == 1)) ? 8'hFF : 8'h00);
        for (int o = 0; o < nops[e]; o++) begin
          int vv;
          vv = (o == 0) ? v0[e] : v1[e];
          q_addr.push_back(a);
          q_rd.push_back((o == 0) ? r0[e] : r1[e]);
          q_elem.push_back(e);
          q_data.push_back((vv != 0) ? ~base : base);
        end
      end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      if (m_rstq) begin m_lc = 1; m_ok = test_en; end
      else begin if (m_lc < 15) m_lc++; m_ok = m_ok & test_en; end
      m_armed = (m_lc >= 15) && m_ok;
      m_state = 0; m_insd = 0; m_gngd = 0; m_loaded = 0; m_fin = 0; m_flag = 0;
      m_instr = 0; m_lim = 0; m_nf = 0; m_pos = 0; m_bc = 0; m_rec = '0;
    end else begin
      bit start;
      start = (m_state == 0) && m_armed && m_loaded && run_req && !ins_shift;
      if (m_state == 0 && m_armed) begin
        if (m_insd && !m_gngd) begin m_instr = {sdi, m_instr[7:1]}; m_loaded = 1; end
        if (m_insd && m_gngd) m_lim = {sdi, m_lim[7:1]};
      end
      case (m_state)
        0: if (start) begin build_ops(m_instr); m_pos = 0; m_state = 1; end
        1: begin
          int a;
          bit miss, lst;
          logic [DW-1:0] d, rd;
          miss = 0;
          a = q_addr[m_pos]; d = q_data[m_pos];
          if (q_rd[m_pos] == 0) m_mem[a] = d;
          else begin
            rd = m_mem[a] ^ ((fault_en && fault_addr == a) ? fault_mask : 8'h00);
            if (rd != d) begin
              if (m_nf >= m_lim) m_flag = 1;
              if (m_nf < 255) m_nf++;
              if (m_instr[2]) begin
                m_rec = {a[3:0], d, rd, q_elem[m_pos][2:0]};
                miss = 1;
              end
            end
          end
          lst = (m_pos == q_addr.size() - 1);
          m_pos++;
          if (miss) begin m_state = 2; m_fin = lst; m_bc = 0; end
          else if (lst) m_state = 4;
        end
        2, 3: if (gng_shift && !ins_shift) begin
          m_rec = m_rec << 1;
          m_bc++;
          if (m_bc == LW) begin m_bc = 0; m_state = m_fin ? 4 : 1; end
          else m_state = 3;
        end
        default: ;
      endcase
      m_insd = ins_shift; m_gngd = gng_shift;
    end
    m_rstq = rst_n;
  end

  // every-cycle comparison, away from the edges
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      if (!rst_n) begin
        chk("R1 result in reset", result, 3'b000);
      end else begin
        chk("R7,R11,R12 result vs model", result,
            {m_flag, m_state == 2, m_state == 4});
        chk("R8 sdo vs model", sdo, (m_state == 2 || m_state == 3) ? m_rec[LW-1] : 1'b0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_reset(input int n, input int drop_at);
    @(negedge clk);
    rst_n = 1'b0; test_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      test_en = (i == drop_at) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    test_en = 1'b1;
    rst_n = 1'b1;
  endtask

  // serial stream: 8 instruction bits, optionally followed by 8 limit bits
  task automatic load(input logic [7:0] ins, input bit with_lim,
                      input logic [7:0] lv, input bit run_on_last);
    int len;
    logic [15:0] s;
    len = with_lim ? 16 : 8;
    s = {lv, ins};
    for (int k = 0; k <= len; k++) begin
      if (k > 0) @(negedge clk);
      ins_shift = (k < len);
      gng_shift = with_lim && (k >= 8) && (k < len);
      sdi = (k > 0) ? s[k-1] : 1'b0;
      run_req = run_on_last && (k == len);
    end
    @(negedge clk);
    sdi = 1'b0; run_req = 1'b0;
  endtask

  task automatic pulse_run();
    run_req = 1'b1;
    @(negedge clk);
    run_req = 1'b0;
  endtask

  task automatic dump(output logic [LW-1:0] bits);
    bits = '0;
    for (int i = 0; i < LW; i++) begin
      @(negedge clk);
      #2;
      bits = {bits[LW-2:0], sdo};
      gng_shift = 1'b1;
    end
    @(negedge clk);
    #2;
    gng_shift = 1'b0;
  endtask

  // run until done, serving halts; returns number of halts and first record
  task automatic serve(output int halts, output logic [LW-1:0] first,
                       output bit done_seen_halted);
    logic [LW-1:0] r;
    halts = 0; first = '0; done_seen_halted = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #3;
      if (result[0]) break;
      if (result[1]) begin
        // wait a few cycles: the flag must stay up (R7)
        repeat (3) @(negedge clk);
        #3;
        chk("R7 wait flag held before retrieval", result[1], 1'b1);
        if (result[0]) done_seen_halted = 1;
        dump(r);
        if (halts == 0) first = r;
        halts++;
      end
    end
  endtask

  function automatic logic [7:0] pat_of(input logic [4:0] bg);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = bg[i % 5];
    return p;
  endfunction

  // ---------------- scenarios ----------------
  initial begin
    int h;
    logic [LW-1:0] fr;
    bit dh;
    logic [7:0] ins, p;

    repeat (2) @(negedge clk);
    cmp_on = 1;

    // R1: short reset pulse leaves the controller unarmed
    do_reset(10, -1);
    load({5'b10110, 1'b0, 2'd0}, 0, 8'h00, 0);
    pulse_run();
    repeat (200) @(negedge clk);
    #3;
    chk("R1 short reset ignores run", result, 3'b000);

    // R2: test enable dropped during reset
    do_reset(20, 7);
    load({5'b10110, 1'b0, 2'd0}, 0, 8'h00, 0);
    pulse_run();
    repeat (200) @(negedge clk);
    #3;
    chk("R2 test_en low in reset ignores run", result, 3'b000);

    // R5, R6: good march run without faults; run before load is ignored
    do_reset(15, -1);
    pulse_run();
    repeat (5) @(negedge clk);
    #3;
    chk("R5 run without instruction ignored", result, 3'b000);
    load({5'b01101, 1'b0, 2'd0}, 0, 8'h00, 0);
    pulse_run();
    serve(h, fr, dh);
    chk("R6 clean march ends passing", result, 3'b001);
    chk("R10 no halts without faults", h, 0);

    // R10, R13: fault without bitmap mode: no halts, fail flag set
    do_reset(16, -1);
    fault_en = 1'b1; fault_addr = 4'd9; fault_mask = 8'h80;
    load({5'b00111, 1'b0, 2'd0}, 0, 8'h00, 0);
    pulse_run();
    serve(h, fr, dh);
    chk("R10 no halt outside bitmap mode", h, 0);
    chk("R13 R12 fault reported at end", result, 3'b101);

    // R3, R5, R7, R8, R9: bitmap march, run request on the last lagged bit
    do_reset(15, -1);
    fault_en = 1'b1; fault_addr = 4'd5; fault_mask = 8'h01;
    ins = {5'b10110, 1'b1, 2'd0};
    p = pat_of(5'b10110);
    load(ins, 0, 8'h00, 1);
    serve(h, fr, dh);
    chk("R9 one halt per failing read", h, 5);
    chk("R8 R3 first record", fr, {4'd5, p, p ^ 8'h01, 3'd1});
    chk("R11 R12 bitmap march end", result, 3'b101);

    // R4, R12, R6: checkerboard with fail limit 3, two failures keep flag low
    do_reset(15, -1);
    fault_en = 1'b1; fault_addr = 4'd3; fault_mask = 8'h10;
    load({5'b11001, 1'b0, 2'd1}, 1, 8'd3, 0);
    pulse_run();
    serve(h, fr, dh);
    chk("R4 R12 limit tolerates two fails", result, 3'b001);

    // R11, R12, R9: solid bitmap, last operation fails, limit 1
    do_reset(15, -1);
    fault_en = 1'b1; fault_addr = 4'd15; fault_mask = 8'h42;
    ins = {5'b01010, 1'b1, 2'd2};
    p = pat_of(5'b01010);
    load(ins, 1, 8'd1, 0);
    pulse_run();
    serve(h, fr, dh);
    chk("R11 done not raised while halted", dh, 1'b0);
    chk("R9 two halts in solid run", h, 2);
    chk("R6 R8 solid first record", fr, {4'd15, p, p ^ 8'h42, 3'd1});
    chk("R11 R12 done after final dump", result, 3'b101);

    fault_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule